// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation analog-to-digital converter that sits behind a four-way analog multiplexer. It chooses an input channel and drives a trial code to an external DAC. It reads back a one-bit comparator decision and settles one result bit per step, from the most significant bit down. The analog comparator, DAC and multiplexer are outside the block. Only their digital connections are ports.

Software controls the block through a small register port. It programs a channel enable mask, a resolution between 2 and 10 bits, a single or continuous scan mode and a power-down bit, and then issues start and stop commands. Each channel has one result register. A scan-done flag marks the end of every pass over the enabled channels. A lower resolution takes fewer comparison steps, so each conversion finishes sooner.

Register map: address 0 is control, address 1 is command, address 2 is status, and addresses 4 to 7 hold the results for channels 0 to 3.

Top module: `sar_scan_sequencer`

## Requirements
- R1: After reset the following values hold:
  - `analogEn` is low and `dacCode` is 0.
  - The control register (address 0) reads 0x2A0. Its fields are: enable mask in bits [3:0] = 0, resolution in bits [7:4] = 10, continuous flag in bit 8 = 0, and power-down in bit 9 = 1.
  - Status (address 2) reads 0, and every result register reads 0.
- R2: With resolution r, a channel's result (address 4+channel, bits [9:0]) equals the channel's input code with the low 10-r bits cleared. This is the left-aligned truncation, given that `cmpIn` is 1 exactly when the input is at or above `dacCode`.
- R3: Every trial code is held on `dacCode` and `muxSel` for two cycles before the comparator is sampled. A pass over k enabled channels at resolution r raises `scanDone` 2·r·k clock edges after the edge that captures the start write.
- R4: A pass visits only the channels whose mask bit is set, in ascending channel order. Results of channels that are not enabled keep their values.
- R5: A start command (write to address 1, bit 0) in single mode (bit 8 = 0) runs exactly one pass. It then sets `scanDone`, clears the busy bit (status bit 1) and starts no further conversion.
- R6: In continuous mode (bit 8 = 1) passes repeat back to back, and each pass overwrites the stored results. A stop command (address 1, bit 1) lets the current pass finish, setting `scanDone`, and the block then goes idle.
- R7: A start with an all-zero enable mask sets `scanDone` at the same edge that captures the start write. No conversion is run and busy stays low.
- R8: The done flag (status bit 0, also the `scanDone` port) clears only when 1 is written to status bit 0. Writing 0 has no effect. A new pass end wins over a simultaneous clear.
- R9: While power-down (bit 9) is set, the following hold:
  - `analogEn` is low and start commands are ignored.
  - Setting it mid-conversion aborts the conversion without changing any result.
  - Clearing it does not resume conversion until a new start command.
- R10: A resolution written below 2 reads back as 2, a value above 10 reads back as 10, and values in between are kept as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` (combinational) |
| cmpIn | input | 1 | Comparator decision: 1 when input is at or above the DAC level |
| muxSel | output | 2 | Analog multiplexer channel select |
| dacCode | output | 10 | Trial code driven to the DAC |
| analogEn | output | 1 | Analog front-end enable, low in power-down |
| scanDone | output | 1 | Pass-complete flag |

## Verification
On every cycle, the assertions check the following:
- Trial code and channel select stay stable through the settle step.
- Power-down leaves the block idle on the next cycle with every result unchanged.
- The done flag follows its set and write-one-clear rules.
- An empty mask never makes the block busy.

Only the bench's scenarios can show that results equal the truncated input codes, in the following cases:
- Every resolution, with the channels visited in ascending order.
- Pass durations that scale with resolution and channel count.
- A stop that lets the running pass end cleanly.
- Conversion that stays off after power-down is lifted until a new start.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int NUM_CH  = 4;
  localparam int RES_MAX = 10;
  localparam int RES_MIN = 2;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int RES_W   = $clog2(RES_MAX + 1);
  localparam int BIT_W   = $clog2(RES_MAX);

  // control register field positions
  localparam int F_RES_LSB = NUM_CH;
  localparam int F_CONT    = NUM_CH + RES_W;
  localparam int F_PD      = F_CONT + 1;

  // register addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CMD  = 1;
  localparam int ADDR_STAT = 2;
  localparam int ADDR_RES0 = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_DECIDE = 2'd2
  } seqStateT;

  typedef struct packed {
    logic             convStart;
    logic             stepDecide;
    logic             lastStep;
    logic             abort;
    logic [CH_W-1:0]  chan;
    logic [BIT_W-1:0] bitPos;
  } dpStrobeT;
endpackage

// File: rtl/sar_seq_regs.sv
module sar_seq_regs
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            regWrEn,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [DATA_W-1:0]               regWrData,
  output logic [DATA_W-1:0]               regRdData,
  input  logic                            doneSet,
  input  logic                            scanBusy,
  input  logic [NUM_CH-1:0][RES_MAX-1:0]  resultBank,
  output logic [NUM_CH-1:0]               chanMask,
  output logic [RES_W-1:0]                resSel,
  output logic                            contMode,
  output logic                            powerDown,
  output logic                            startCmd,
  output logic                            stopCmd,
  output logic                            scanDone
);
  logic wrCtrl, wrCmd, wrStat;
  logic [ADDR_W-1:0] resOff;
  logic unusedWrBits;

  assign wrCtrl = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
  assign wrCmd  = regWrEn && (regAddr == ADDR_W'(ADDR_CMD));
  assign wrStat = regWrEn && (regAddr == ADDR_W'(ADDR_STAT));

  assign startCmd = wrCmd && regWrData[0];
  assign stopCmd  = wrCmd && regWrData[1];
  assign unusedWrBits = ^regWrData[DATA_W-1:F_PD+1];

  function automatic logic [RES_W-1:0] clampRes(input logic [RES_W-1:0] raw);
    if (int'(raw) < RES_MIN)      return RES_W'(RES_MIN);
    else if (int'(raw) > RES_MAX) return RES_W'(RES_MAX);
    else                          return raw;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanMask  <= '0;
      resSel    <= RES_W'(RES_MAX);
      contMode  <= 1'b0;
      powerDown <= 1'b1;
    end else if (wrCtrl) begin
      chanMask  <= regWrData[NUM_CH-1:0];
      resSel    <= clampRes(regWrData[F_RES_LSB +: RES_W]);
      contMode  <= regWrData[F_CONT];
      powerDown <= regWrData[F_PD];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       scanDone <= 1'b0;
    else if (doneSet)                scanDone <= 1'b1;
    else if (wrStat && regWrData[0]) scanDone <= 1'b0;
  end

  assign resOff = regAddr - ADDR_W'(ADDR_RES0);

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) begin
      regRdData[NUM_CH-1:0]          = chanMask;
      regRdData[F_RES_LSB +: RES_W]  = resSel;
      regRdData[F_CONT]              = contMode;
      regRdData[F_PD]                = powerDown;
    end else if (regAddr == ADDR_W'(ADDR_STAT)) begin
      regRdData[0] = scanDone;
      regRdData[1] = scanBusy;
    end else if (regAddr >= ADDR_W'(ADDR_RES0) && int'(resOff) < NUM_CH) begin
      regRdData[RES_MAX-1:0] = resultBank[resOff[CH_W-1:0]];
    end
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic [RES_W-1:0]  resSel,
  input  logic              contMode,
  input  logic              powerDown,
  input  logic              startCmd,
  input  logic              stopCmd,
  output dpStrobeT          strb,
  output logic [CH_W-1:0]   muxSel,
  output logic              scanBusy,
  output logic              inDecide,
  output logic              doneSet
);
  seqStateT state, nextState;
  logic [CH_W-1:0]  chanReg, nextChan;
  logic [BIT_W-1:0] bitPos, nextBit, lowBit, nextLow;
  logic             stopPending;
  logic             firstFound, nextFound, launch;
  logic [CH_W-1:0]  firstIdx, nextIdx;

  // lowest enabled channel overall and lowest one above the current channel
  always_comb begin
    firstFound = 1'b0;
    firstIdx   = '0;
    nextFound  = 1'b0;
    nextIdx    = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (chanMask[c]) begin
        firstFound = 1'b1;
        firstIdx   = CH_W'(c);
        if (c > int'(chanReg)) begin
          nextFound = 1'b1;
          nextIdx   = CH_W'(c);
        end
      end
    end
  end

  always_comb begin
    strb        = '0;
    strb.chan   = chanReg;
    strb.bitPos = bitPos;
    doneSet     = 1'b0;
    launch      = 1'b0;
    nextState   = state;
    nextChan    = chanReg;
    nextBit     = bitPos;
    nextLow     = lowBit;
    if (powerDown) begin
      nextState  = ST_IDLE;
      strb.abort = (state != ST_IDLE);
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startCmd) begin
            if (firstFound) begin
              launch   = 1'b1;
              nextChan = firstIdx;
            end else begin
              doneSet = 1'b1;
            end
          end
        end
        ST_SETTLE: nextState = ST_DECIDE;
        ST_DECIDE: begin
          strb.stepDecide = 1'b1;
          strb.lastStep   = (bitPos == lowBit);
          if (bitPos == lowBit) begin
            if (nextFound) begin
              launch   = 1'b1;
              nextChan = nextIdx;
            end else begin
              doneSet = 1'b1;
              if (contMode && !stopPending && firstFound) begin
                launch   = 1'b1;
                nextChan = firstIdx;
              end else begin
                nextState = ST_IDLE;
              end
            end
          end else begin
            nextBit   = bitPos - 1'b1;
            nextState = ST_SETTLE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
    if (launch) begin
      strb.convStart = 1'b1;
      nextBit        = BIT_W'(RES_MAX - 1);
      nextLow        = BIT_W'(RES_MAX - int'(resSel));
      nextState      = ST_SETTLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      chanReg     <= '0;
      bitPos      <= '0;
      lowBit      <= '0;
      stopPending <= 1'b0;
    end else begin
      state   <= nextState;
      chanReg <= nextChan;
      bitPos  <= nextBit;
      lowBit  <= nextLow;
      if (state == ST_IDLE && startCmd) stopPending <= 1'b0;
      else if (stopCmd)                 stopPending <= 1'b1;
    end
  end

  assign muxSel   = chanReg;
  assign scanBusy = (state != ST_IDLE);
  assign inDecide = (state == ST_DECIDE);
endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
  import sar_seq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobeT                       strb,
  input  logic                           cmpIn,
  output logic [RES_MAX-1:0]             dacCode,
  output logic [NUM_CH-1:0][RES_MAX-1:0] resultBank
);
  logic [RES_MAX-1:0] decided, trialNext;

  assign decided   = cmpIn ? dacCode : (dacCode & ~(RES_MAX'(1) << strb.bitPos));
  assign trialNext = RES_MAX'(1) << (strb.bitPos - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dacCode <= '0;
    else if (strb.abort)      dacCode <= '0;
    else if (strb.convStart)  dacCode <= RES_MAX'(1) << (RES_MAX - 1);
    else if (strb.stepDecide) dacCode <= strb.lastStep ? decided : (decided | trialNext);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gResult
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        resultBank[g] <= '0;
      else if (strb.stepDecide && strb.lastStep && !strb.abort && strb.chan == CH_W'(g))
        resultBank[g] <= decided;
    end
  end
endmodule

// File: rtl/sar_scan_sequencer.sv
module sar_scan_sequencer
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               cmpIn,
  output logic [CH_W-1:0]    muxSel,
  output logic [RES_MAX-1:0] dacCode,
  output logic               analogEn,
  output logic               scanDone
);
  logic [NUM_CH-1:0]              chanMask;
  logic [RES_W-1:0]               resSel;
  logic                           contMode, powerDown, startCmd, stopCmd;
  logic                           doneSet, scanBusy, inDecide;
  dpStrobeT                       strb;
  logic [NUM_CH-1:0][RES_MAX-1:0] resultBank;

  sar_seq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .doneSet(doneSet),
    .scanBusy(scanBusy), .resultBank(resultBank), .chanMask(chanMask),
    .resSel(resSel), .contMode(contMode), .powerDown(powerDown),
    .startCmd(startCmd), .stopCmd(stopCmd), .scanDone(scanDone)
  );

  sar_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .chanMask(chanMask), .resSel(resSel),
    .contMode(contMode), .powerDown(powerDown), .startCmd(startCmd),
    .stopCmd(stopCmd), .strb(strb), .muxSel(muxSel), .scanBusy(scanBusy),
    .inDecide(inDecide), .doneSet(doneSet)
  );

  sar_seq_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpIn(cmpIn),
    .dacCode(dacCode), .resultBank(resultBank)
  );

  assign analogEn = !powerDown;
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           analogEn,
  input logic                           scanBusy,
  input logic                           inDecide,
  input logic                           doneSet,
  input logic                           scanDone,
  input logic [RES_MAX-1:0]             dacCode,
  input logic [CH_W-1:0]                muxSel,
  input logic [NUM_CH-1:0][RES_MAX-1:0] resultBank,
  input logic [NUM_CH-1:0]              chanMask,
  input logic                           regWrEn,
  input logic [ADDR_W-1:0]              regAddr,
  input logic [DATA_W-1:0]              regWrData
);
  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    inDecide |-> ($stable(dacCode) && $stable(muxSel))); // R3
  AST_PD_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    !analogEn |=> !scanBusy); // R9
  AST_PD_KEEPS_RESULTS: assert property (@(posedge clk) disable iff (!rstN)
    !analogEn |=> $stable(resultBank)); // R9
  AST_IDLE_RESULTS: assert property (@(posedge clk) disable iff (!rstN)
    !scanBusy |=> $stable(resultBank)); // R5
  AST_EMPTY_MASK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!scanBusy && chanMask == '0) |=> !scanBusy); // R7
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rstN)
    doneSet |=> scanDone); // R8
  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(ADDR_STAT) && regWrData[0] && !doneSet) |=> !scanDone); // R8
endmodule

bind sar_scan_sequencer sar_seq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .analogEn(analogEn), .scanBusy(scanBusy),
  .inDecide(inDecide), .doneSet(doneSet), .scanDone(scanDone),
  .dacCode(dacCode), .muxSel(muxSel), .resultBank(resultBank),
  .chanMask(chanMask), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData)
);

// File: tb/tb_sar_scan_sequencer.sv
module tb_sar_scan_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        cmpIn;
  logic [1:0]  muxSel;
  logic [9:0]  dacCode;
  logic        analogEn;
  logic        scanDone;

  logic [9:0]  anaVal [4];
  logic [9:0]  expRes [4];
  int          nCmp = 0;
  int          nBad = 0;
  int          orderLog [16];
  int          logN = 0;
  logic [9:0]  prevDac = '0;

  always #4 clk = ~clk;

  assign cmpIn = (anaVal[muxSel] >= dacCode);

  sar_scan_sequencer dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmpIn(cmpIn),
    .muxSel(muxSel), .dacCode(dacCode), .analogEn(analogEn), .scanDone(scanDone)
  );

  // log the channel of each conversion start (trial code steps to 0x200)
  always @(negedge clk) begin
    if (analogEn && dacCode == 10'h200 && prevDac != 10'h200) begin
      if (logN < 16) orderLog[logN] = int'(muxSel);
      logN++;
    end
    prevDac = dacCode;
  end

  task automatic check(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output int v);
    @(negedge clk);
    regAddr = a;
    #1 v = int'(regRdData);
  endtask

  function automatic logic [15:0] ctrlWord(input int mask, input int res, input bit cont, input bit pd);
    return 16'(mask & 15) | 16'((res & 15) << 4) | 16'(cont) << 8 | 16'(pd) << 9;
  endfunction

  function automatic logic [9:0] trunc(input logic [9:0] v, input int r);
    return v & ~10'((1 << (10 - r)) - 1);
  endfunction

  // start write then count edges until done
  task automatic startAndWait(output int n);
    regWrite(3'd1, 16'h0001);
    n = 0;
    while (!scanDone && n < 5000) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic waitDone();
    int n = 0;
    while (!scanDone && n < 5000) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic checkResults(input string req);
    int v;
    for (int c = 0; c < 4; c++) begin
      regRead(3'(4 + c), v);
      check(req, v, int'(expRes[c]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int v, n, cnt;
    logic [9:0] oldRes;
    for (int c = 0; c < 4; c++) begin anaVal[c] = '0; expRes[c] = '0; end
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 analogEn", int'(analogEn), 0);
    check("R1 dacCode", int'(dacCode), 0);
    check("R1 scanDone", int'(scanDone), 0);
    regRead(3'd0, v); check("R1 ctrl", v, 16'h2A0);
    regRead(3'd2, v); check("R1 status", v, 0);
    checkResults("R1 results");

    // R10 resolution clamp
    regWrite(3'd0, ctrlWord(0, 0, 0, 1)); regRead(3'd0, v); check("R10 res 0", (v >> 4) & 15, 2);
    regWrite(3'd0, ctrlWord(0, 1, 0, 1)); regRead(3'd0, v); check("R10 res 1", (v >> 4) & 15, 2);
    regWrite(3'd0, ctrlWord(0, 15, 0, 1)); regRead(3'd0, v); check("R10 res 15", (v >> 4) & 15, 10);
    regWrite(3'd0, ctrlWord(0, 11, 0, 1)); regRead(3'd0, v); check("R10 res 11", (v >> 4) & 15, 10);
    regWrite(3'd0, ctrlWord(0, 7, 0, 1)); regRead(3'd0, v); check("R10 res 7", (v >> 4) & 15, 7);

    // R9 start ignored while powered down
    regWrite(3'd0, ctrlWord(15, 10, 0, 1));
    regWrite(3'd1, 16'h0001);
    repeat (30) @(posedge clk);
    regRead(3'd2, v); check("R9 start ignored in power-down", v, 0);
    check("R9 analogEn low", int'(analogEn), 0);
    checkResults("R9 results untouched");

    // R2 / R3 sweep of resolutions and input patterns, all channels
    for (int r = 2; r <= 10; r++) begin
      for (int p = 0; p < 6; p++) begin
        for (int c = 0; c < 4; c++) begin
          anaVal[c] = 10'((p * 389 + c * 277 + r * 53 + 11) % 1024);
          expRes[c] = trunc(anaVal[c], r);
        end
        regWrite(3'd0, ctrlWord(15, r, 0, 0));
        regWrite(3'd2, 16'h0001);
        startAndWait(n);
        check("R3 pass length", n, 8 * r);
        checkResults("R2 result");
      end
    end

    // R4 / R5 / R3 every non-empty mask at full resolution
    for (int m = 1; m < 16; m++) begin
      anaVal[0] = 10'h0C7 ^ 10'(m << 1);
      anaVal[1] = 10'h1F3 ^ 10'(m << 1);
      anaVal[2] = 10'h35A ^ 10'(m << 1);
      anaVal[3] = 10'h3FF ^ 10'(m << 1);
      for (int c = 0; c < 4; c++) if (m[c]) expRes[c] = anaVal[c];
      regWrite(3'd0, ctrlWord(m, 10, 0, 0));
      regWrite(3'd2, 16'h0001);
      logN = 0;
      startAndWait(n);
      check("R3 masked pass length", n, 20 * $countones(4'(m)));
      cnt = 0;
      for (int c = 0; c < 4; c++) begin
        if (m[c]) begin
          check("R4 channel order", (cnt < 16) ? orderLog[cnt] : -1, c);
          cnt++;
        end
      end
      check("R4 conversion count", logN, cnt);
      checkResults("R4 enabled and disabled results");
      repeat (30) @(posedge clk);
      regRead(3'd2, v); check("R5 single pass idles", v, 1);
      check("R5 no further conversion", logN, cnt);
    end

    // R8 done flag write-one-clear
    regWrite(3'd2, 16'h0000);
    check("R8 write 0 keeps done", int'(scanDone), 1);
    regWrite(3'd2, 16'h0001);
    check("R8 write 1 clears done", int'(scanDone), 0);

    // R7 empty mask
    regWrite(3'd0, ctrlWord(0, 10, 0, 0));
    logN = 0;
    startAndWait(n);
    check("R7 empty mask done at once", n, 0);
    repeat (10) @(posedge clk);
    regRead(3'd2, v); check("R7 empty mask not busy", v, 1);
    check("R7 no conversion", logN, 0);
    checkResults("R7 results unchanged");

    // R6 continuous mode with stop
    regWrite(3'd2, 16'h0001);
    for (int c = 0; c < 4; c++) anaVal[c] = 10'(100 + 200 * c);
    expRes[0] = trunc(anaVal[0], 4);
    expRes[2] = trunc(anaVal[2], 4);
    regWrite(3'd0, ctrlWord(5, 4, 1, 0));
    startAndWait(n);
    regWrite(3'd2, 16'h0001);
    checkResults("R6 first pass");
    anaVal[0] = 10'h3C1; anaVal[2] = 10'h055;
    expRes[0] = trunc(anaVal[0], 4);
    expRes[2] = trunc(anaVal[2], 4);
    waitDone(); regWrite(3'd2, 16'h0001);
    waitDone(); regWrite(3'd2, 16'h0001);
    checkResults("R6 later pass overwrites");
    regRead(3'd2, v); check("R6 still running", v, 2);
    regWrite(3'd1, 16'h0002);
    cnt = 0;
    do begin regRead(3'd2, v); cnt++; end while ((v & 2) != 0 && cnt < 200);
    check("R6 stop ends after pass with done", v, 1);
    logN = 0;
    repeat (40) @(posedge clk);
    regRead(3'd2, v); check("R6 stays idle after stop", v, 1);
    check("R6 no conversion after stop", logN, 0);
    checkResults("R6 results after stop");

    // R9 abort mid-conversion
    regWrite(3'd2, 16'h0001);
    oldRes = expRes[0];
    anaVal[0] = 10'h123;
    regWrite(3'd0, ctrlWord(1, 10, 0, 0));
    regWrite(3'd1, 16'h0001);
    repeat (6) @(posedge clk);
    regWrite(3'd0, ctrlWord(1, 10, 0, 1));
    @(negedge clk);
    check("R9 analogEn low", int'(analogEn), 0);
    regRead(3'd2, v); check("R9 abort idles without done", v, 0);
    regRead(3'd4, v); check("R9 abort keeps result", v, int'(oldRes));
    regWrite(3'd0, ctrlWord(1, 10, 0, 0));
    logN = 0;
    repeat (40) @(posedge clk);
    regRead(3'd2, v); check("R9 no resume without start", v, 0);
    check("R9 no conversion without start", logN, 0);
    regRead(3'd4, v); check("R9 result still kept", v, int'(oldRes));
    startAndWait(n);
    check("R9 restart pass length", n, 20);
    regRead(3'd4, v); check("R9 converts after start", v, 16'h123);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule